// File: doc/BRIEF.md
# Flash Erase Status and Ready/Busy Tracker

This block sits beside a NOR-style flash array and follows the host write bus. It recognises the unlock-prefixed program, chip-erase and block-erase command sequences, and it runs the internal operation as a cycle countdown. It drives a registered ready/busy line and returns status bytes on reads while an operation is in progress. The status byte carries two flags. Bit 3 shows whether the block-erase collection window has closed. Bit 2 flips on each read, but only when the read address lands in a block that is marked for erase.

After a block erase is issued, a timed window stays open. During that window, single-cycle 0x30 writes add further blocks to the set being erased. The erasing set is held as a bitmask indexed by the top address bits. A single-cycle 0xB0 write suspends a running erase. While suspended, reads of blocks that are not being erased return array data again. A single-cycle 0x30 write resumes the erase, and the remaining countdown picks up where it stopped. Command sequences use 0xAA at word 0x555, then 0x55 at word 0x2AA, compared on the low 11 address bits.

Top module: `fsr_status_top`

## Requirements
- R1: After reset, `ready_o` is 1, and a read returns `arr_data` one cycle after the read strobe.
- R2: The program sequence is AA@555, 55@2AA, A0@555, then any address and data. `ready_o` drops after the edge that samples the fourth strobe and rises exactly PROG_CYC cycles later. Reads during the program return 0x00.
- R3: The erase sequence is AA@555, 55@2AA, 80@555, AA@555, 55@2AA. A sixth write of 0x30 at a block address starts a block erase. A sixth write of 0x10 at 555 starts a chip erase, which marks every block and skips the window. `ready_o` drops after the sixth strobe in both cases.
- R4: A block erase first opens a window of WIN_CYC cycles. During the window, status reads return 0x00 (bit 3 = 0). Once the window closes, bit 3 reads 1 and the erase starts.
- R5: A single-cycle 0x30 write during the window adds the block of its address (bits AW-1 down to AW-BLK_W) to the erase set and restarts the window.
- R6: Once the erase has started, no write other than suspend changes the state. The erase ends after ERASE_CYC cycles spent in the erasing state.
- R7: During an erase, a read of a marked block returns bit 3 = 1, with bit 2 equal to a toggle. The toggle is 0 at the first read after the erase starts and flips on every such read. Reads of unmarked blocks return 0x08.
- R8: A single-cycle 0xB0 write during an erase raises `ready_o` and suspends the erase. Reads of unmarked blocks then return `arr_data`, and reads of marked blocks return status with the toggle.
- R9: A program sequence aimed at a marked block during suspend makes bit 2 read 1 steadily on marked-block reads, until the erase is resumed.
- R10: A single-cycle 0x30 write during suspend drops `ready_o` and clears the R9 flag. `ready_o` rises once the erasing state has been occupied for ERASE_CYC cycles in total.
- R11: While busy, program, erase and suspend writes have no effect, except a suspend during an erase.
- R12: When the erase completes, the erase set is cleared, so reads of formerly marked blocks return `arr_data`.
- R13: `ready_o` is 1 for ready and 0 for busy. It can therefore be wire-ANDed with other ready/busy sources, the way an open-drain line pulled high behaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data (command byte) |
| rd_stb | input | 1 | One-cycle host read strobe |
| rd_addr | input | AW | Read address |
| arr_data | input | DW | Array data for `rd_addr` |
| rd_data | output | DW | Registered read result |
| ready_o | output | 1 | Ready (1) / busy (0) |

## Verification
A write acts at the edge that samples its strobe, so `ready_o` is checked at the falling edge just after that sample. A completion at edge N is checked as still busy at the falling edge after N-1 and ready after N. The due edge is computed from the sample edge plus PROG_CYC, WIN_CYC or ERASE_CYC. When an erase is suspended and resumed, the due edge subtracts the cycles already spent erasing. Read results are due one edge after the read strobe is sampled. A scoreboard queue holds each expected byte and pops it at the falling edge after that sample, with the toggle value tracked from the number of marked-block reads.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WIN,
    ST_ERASE,
    ST_SUSP
  } fsr_state_e;

  localparam int          ULK_W    = 11;
  localparam logic [10:0] ULK_A1   = 11'h555;
  localparam logic [10:0] ULK_A2   = 11'h2AA;
  localparam logic [7:0]  C_UNLK1  = 8'hAA;
  localparam logic [7:0]  C_UNLK2  = 8'h55;
  localparam logic [7:0]  C_PROG   = 8'hA0;
  localparam logic [7:0]  C_ERSET  = 8'h80;
  localparam logic [7:0]  C_CHIP   = 8'h10;
  localparam logic [7:0]  C_BLK    = 8'h30;
  localparam logic [7:0]  C_SUSP   = 8'hB0;
  localparam int          TMR_BIT  = 3;
  localparam int          TOG_BIT  = 2;
endpackage

// File: rtl/fsr_cmd_seq.sv
module fsr_cmd_seq
  import fsr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_stb,
  input  logic [ULK_W-1:0] wr_lo,
  input  logic [DW-1:0]    wr_data,
  output logic             go_prog,
  output logic             go_chip,
  output logic             go_blk,
  output logic             one_susp,
  output logic             one_30
);
  logic [2:0] step, step_n;
  logic       a1, a2;
  logic [7:0] d;

  assign a1 = (wr_lo == ULK_A1);
  assign a2 = (wr_lo == ULK_A2);
  assign d  = wr_data[7:0];

  always_comb begin
    step_n   = step;
    go_prog  = 1'b0;
    go_chip  = 1'b0;
    go_blk   = 1'b0;
    one_susp = 1'b0;
    one_30   = 1'b0;
    if (we_stb) begin
      case (step)
        3'd0: begin
          if (a1 && d == C_UNLK1) step_n = 3'd1;
          else begin
            one_susp = (d == C_SUSP);
            one_30   = (d == C_BLK);
          end
        end
        3'd1: step_n = (a2 && d == C_UNLK2) ? 3'd2 : 3'd0;
        3'd2: begin
          if (a1 && d == C_PROG)       step_n = 3'd3;
          else if (a1 && d == C_ERSET) step_n = 3'd4;
          else                         step_n = 3'd0;
        end
        3'd3: begin
          go_prog = 1'b1;
          step_n  = 3'd0;
        end
        3'd4: step_n = (a1 && d == C_UNLK1) ? 3'd5 : 3'd0;
        3'd5: step_n = (a2 && d == C_UNLK2) ? 3'd6 : 3'd0;
        default: begin
          if (a1 && d == C_CHIP) go_chip = 1'b1;
          else if (d == C_BLK)   go_blk  = 1'b1;
          step_n = 3'd0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step <= 3'd0;
    else     step <= step_n;
  end
endmodule

// File: rtl/fsr_op_ctrl.sv
module fsr_op_ctrl
  import fsr_pkg::*;
#(
  parameter int BLK_W     = 3,
  parameter int WIN_CYC   = 2_500_000,
  parameter int ERASE_CYC = 4_000_000,
  parameter int PROG_CYC  = 500,
  localparam int NBLK     = 1 << BLK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_prog,
  input  logic             go_chip,
  input  logic             go_blk,
  input  logic             one_susp,
  input  logic             one_30,
  input  logic [BLK_W-1:0] wr_blk,
  output fsr_state_e       st,
  output logic [NBLK-1:0]  mask,
  output logic             hit,
  output logic             tog_clr,
  output logic             ready_o
);
  localparam int MAX_WE = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
  localparam int MAXC   = (MAX_WE > PROG_CYC) ? MAX_WE : PROG_CYC;
  localparam int CW     = $clog2(MAXC + 1);

  fsr_state_e      st_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic [NBLK-1:0] mask_n, blk_bit;
  logic            hit_n;

  assign blk_bit = NBLK'(1) << wr_blk;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    mask_n  = mask;
    hit_n   = hit;
    tog_clr = 1'b0;
    case (st)
      ST_IDLE: begin
        if (go_prog) begin
          st_n  = ST_PROG;
          cnt_n = CW'(PROG_CYC - 1);
        end else if (go_chip) begin
          st_n    = ST_ERASE;
          cnt_n   = CW'(ERASE_CYC - 1);
          mask_n  = '1;
          tog_clr = 1'b1;
        end else if (go_blk) begin
          st_n   = ST_WIN;
          cnt_n  = CW'(WIN_CYC - 1);
          mask_n = blk_bit;
        end
      end
      ST_PROG: begin
        if (cnt == '0) st_n = ST_IDLE;
        else           cnt_n = cnt - 1'b1;
      end
      ST_WIN: begin
        if (one_30) begin
          mask_n = mask | blk_bit;
          cnt_n  = CW'(WIN_CYC - 1);
        end else if (cnt == '0) begin
          st_n    = ST_ERASE;
          cnt_n   = CW'(ERASE_CYC - 1);
          tog_clr = 1'b1;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_ERASE: begin
        if (cnt == '0) begin
          st_n   = ST_IDLE;
          mask_n = '0;
        end else begin
          cnt_n = cnt - 1'b1;
          if (one_susp) st_n = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (one_30) begin
          st_n  = ST_ERASE;
          hit_n = 1'b0;
        end else if (go_prog && mask[wr_blk]) begin
          hit_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      mask    <= '0;
      hit     <= 1'b0;
      ready_o <= 1'b1;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      mask    <= mask_n;
      hit     <= hit_n;
      ready_o <= (st_n == ST_IDLE) || (st_n == ST_SUSP);
    end
  end
endmodule

// File: rtl/fsr_rd_path.sv
module fsr_rd_path
  import fsr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int BLK_W = 3,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  fsr_state_e       st,
  input  logic [NBLK-1:0]  mask,
  input  logic             hit,
  input  logic             tog_clr,
  input  logic             rd_stb,
  input  logic [BLK_W-1:0] rd_blk,
  input  logic [DW-1:0]    arr_data,
  output logic [DW-1:0]    rd_data
);
  logic          tog, flip, in_m;
  logic [DW-1:0] rd_n;

  assign in_m = mask[rd_blk];

  always_comb begin
    rd_n = arr_data;
    flip = 1'b0;
    case (st)
      ST_PROG, ST_WIN: rd_n = '0;
      ST_ERASE: begin
        rd_n          = '0;
        rd_n[TMR_BIT] = 1'b1;
        if (in_m) begin
          rd_n[TOG_BIT] = tog;
          flip          = 1'b1;
        end
      end
      ST_SUSP: begin
        if (in_m) begin
          rd_n          = '0;
          rd_n[TMR_BIT] = 1'b1;
          rd_n[TOG_BIT] = hit | tog;
          flip          = !hit;
        end
      end
      default: rd_n = arr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (tog_clr)          tog <= 1'b0;
      else if (rd_stb && flip) tog <= ~tog;
      if (rd_stb) rd_data <= rd_n;
    end
  end
endmodule

// File: rtl/fsr_status_top.sv
module fsr_status_top
  import fsr_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int BLK_W     = 3,
  parameter int WIN_CYC   = 2_500_000,
  parameter int ERASE_CYC = 4_000_000,
  parameter int PROG_CYC  = 500,
  localparam int NBLK     = 1 << BLK_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          ready_o
);
  fsr_state_e      st;
  logic [NBLK-1:0] mask;
  logic            hit, tog_clr;
  logic            go_prog, go_chip, go_blk, one_susp, one_30;
  logic            unused_addr;

  assign unused_addr = ^{wr_addr, rd_addr};

  fsr_cmd_seq #(.DW(DW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .we_stb   (we_stb),
    .wr_lo    (wr_addr[ULK_W-1:0]),
    .wr_data  (wr_data),
    .go_prog  (go_prog),
    .go_chip  (go_chip),
    .go_blk   (go_blk),
    .one_susp (one_susp),
    .one_30   (one_30)
  );

  fsr_op_ctrl #(
    .BLK_W(BLK_W), .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .go_prog  (go_prog),
    .go_chip  (go_chip),
    .go_blk   (go_blk),
    .one_susp (one_susp),
    .one_30   (one_30),
    .wr_blk   (wr_addr[AW-1 -: BLK_W]),
    .st       (st),
    .mask     (mask),
    .hit      (hit),
    .tog_clr  (tog_clr),
    .ready_o  (ready_o)
  );

  fsr_rd_path #(.DW(DW), .BLK_W(BLK_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .mask     (mask),
    .hit      (hit),
    .tog_clr  (tog_clr),
    .rd_stb   (rd_stb),
    .rd_blk   (rd_addr[AW-1 -: BLK_W]),
    .arr_data (arr_data),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/fsr_status_chk.sv
module fsr_status_chk
  import fsr_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NBLK = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            we_stb,
  input logic [DW-1:0]   wr_data,
  input logic            rd_stb,
  input logic [DW-1:0]   arr_data,
  input logic [DW-1:0]   rd_data,
  input logic            ready_o,
  input fsr_state_e      st,
  input logic [NBLK-1:0] mask
);
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(rd_stb) && $past(st) == ST_IDLE) |-> rd_data == $past(arr_data)); // R1
  AST_WIN_GROWS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && st == ST_WIN && $past(st) == ST_WIN) |-> ((mask & $past(mask)) == $past(mask))); // R5
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && st == ST_ERASE && $past(st) == ST_ERASE) |-> mask == $past(mask)); // R6
  AST_READY_STATE: assert property (@(posedge clk) disable iff (rst)
    ready_o == (st == ST_IDLE || st == ST_SUSP)); // R8
  AST_SUSP_BY_CMD: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && st == ST_SUSP && $past(st) == ST_ERASE) |-> ($past(we_stb) && $past(wr_data[7:0]) == C_SUSP)); // R8
  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && st == ST_IDLE && $past(st) == ST_ERASE) |-> mask == '0); // R12
endmodule

bind fsr_status_top fsr_status_chk #(.DW(DW), .NBLK(NBLK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .we_stb   (we_stb),
  .wr_data  (wr_data),
  .rd_stb   (rd_stb),
  .arr_data (arr_data),
  .rd_data  (rd_data),
  .ready_o  (ready_o),
  .st       (st),
  .mask     (mask)
);

// File: tb/test_fsr_status_top.sv
module test_fsr_status_top;
  localparam int AW = 16, DW = 8, W = 20, E = 40, P = 10;

  logic          clk = 1'b0, rst = 1'b1;
  logic          we_stb = 1'b0, rd_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data, arr_data;
  logic          ready_o, peer_rdy = 1'b1, rb;
  int            cyc = 0, n_cmp = 0, n_bad = 0;
  logic          rd_seen = 1'b0, finished = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          tog_exp;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) rd_seen <= rd_stb;

  assign arr_data = rd_addr[7:0] ^ 8'h5A;
  assign rb = ready_o & peer_rdy;  // wire-AND of open-drain ready lines

  fsr_status_top #(.AW(AW), .DW(DW), .BLK_W(3), .WIN_CYC(W), .ERASE_CYC(E), .PROG_CYC(P))
  i_fsr_status_top (
    .clk(clk), .rst(rst), .we_stb(we_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .arr_data(arr_data), .rd_data(rd_data),
    .ready_o(ready_o)
  );

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rd_data !== e) begin
        n_bad++;
        $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string t);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: ready actual %b expected %b", t, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    we_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    we_stb = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
    rd_stb = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  // marked-block status read with tracked toggle
  task automatic rd_tog(input logic [AW-1:0] a, input string t);
    rd(a, {4'h0, 1'b1, tog_exp, 2'b00}, t);
    tog_exp = ~tog_exp;
  endtask

  task automatic wait_done(input int edge_n, input string t);
    while (cyc < edge_n - 1) @(negedge clk);
    chk(rb, 1'b0, t);
    @(negedge clk);
    chk(rb, 1'b1, t);
  endtask

  task automatic unlock;
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t0, ta, s, q, r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rb, 1'b1, "R1");
    rd(16'h0123, 8'h23 ^ 8'h5A, "R1");

    // R2 program, R11 suspend ignored while programming
    unlock();
    chk(rb, 1'b1, "R2");
    wr(16'h0555, 8'hA0);
    wr(16'h1234, 8'h77);
    t0 = cyc;
    chk(rb, 1'b0, "R2");
    rd(16'h1234, 8'h00, "R2");
    wr(16'h0000, 8'hB0);
    chk(rb, 1'b0, "R11");
    wait_done(t0 + P, "R2");
    rd(16'h1234, 8'h34 ^ 8'h5A, "R2");

    // R3 block erase on block 2, R4 window, R5 add block 5
    unlock(); wr(16'h0555, 8'h80); unlock();
    wr(16'h4000, 8'h30);
    chk(rb, 1'b0, "R3");
    rd(16'h4010, 8'h00, "R4");
    repeat (5) @(negedge clk);
    wr(16'hA000, 8'h30);
    ta = cyc;
    s  = ta + W;
    while (cyc < s - 2) @(negedge clk);
    rd(16'h4010, 8'h00, "R4");
    @(negedge clk);
    tog_exp = 1'b0;
    rd_tog(16'h4010, "R4");
    rd_tog(16'hA004, "R5");
    rd(16'h2000, 8'h08, "R7");
    rd_tog(16'h4000, "R7");
    // R6 / R11: program and extra block-erase ignored while erasing
    unlock(); wr(16'h0555, 8'hA0); wr(16'h2000, 8'h12);
    wr(16'h6000, 8'h30);
    rd(16'h6000, 8'h08, "R6");
    chk(rb, 1'b0, "R11");
    // R8 suspend
    wr(16'h0000, 8'hB0);
    q = cyc;
    chk(rb, 1'b1, "R8");
    rd(16'h2000, 8'h00 ^ 8'h5A, "R8");
    rd_tog(16'h4000, "R8");
    // R9 program to marked block while suspended
    unlock(); wr(16'h0555, 8'hA0); wr(16'h4008, 8'h99);
    rd(16'h4008, 8'h0C, "R9");
    rd(16'h4008, 8'h0C, "R9");
    chk(rb, 1'b1, "R9");
    // R10 resume
    wr(16'h0000, 8'h30);
    r = cyc;
    chk(rb, 1'b0, "R10");
    rd_tog(16'h4000, "R10");
    wait_done(r + E - (q - s), "R10");
    // R12 erase set cleared
    rd(16'h4000, 8'h00 ^ 8'h5A, "R12");
    rd(16'hA000, 8'h00 ^ 8'h5A, "R12");

    // R3 chip erase: no window, all blocks marked
    unlock(); wr(16'h0555, 8'h80); unlock();
    wr(16'h0555, 8'h10);
    t0 = cyc;
    chk(rb, 1'b0, "R3");
    tog_exp = 1'b0;
    rd_tog(16'hE000, "R3");
    rd_tog(16'h0000, "R7");
    wait_done(t0 + E, "R6");
    rd(16'hE000, 8'h00 ^ 8'h5A, "R12");

    // R13 wired-AND ready line
    peer_rdy = 1'b0;
    @(negedge clk);
    chk(rb, 1'b0, "R13");
    chk(ready_o, 1'b1, "R13");
    peer_rdy = 1'b1;
    @(negedge clk);
    chk(rb, 1'b1, "R13");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule